// File: doc/BRIEF.md
# Serial Display RAM Write Controller

This block sits at the host-facing edge of a monochrome dot-matrix display controller. A host sends bytes one bit at a time over a synchronous serial link made of a clock, a data line and an active-low enable. A select line sampled with the last bit of each byte marks the byte as a command or as display data. Command bytes load the column (X) address, load the bank (Y) address, or set the addressing mode. Data bytes are written into a banked display memory at the current address, and the address then steps on by one.

The memory has 102 columns and nine banks. Banks 0 to 7 store a full byte per column. Bank 8 stores a single bit per column, so the panel has 65 rows in all. In horizontal mode each write moves to the next column, and the bank advances when the column wraps. In vertical mode each write moves to the next bank, and the column advances when the bank wraps. The row-scan side reads the memory through a combinational port that is addressed by column and bank.

Top module: `serial_dotram_writer`

## Requirements
- R1: While `ser_en_n` is low, each rising edge of `ser_clk` shifts in one bit of `ser_din`, most significant bit first. A byte is complete on the eighth such edge.
- R2: While `ser_en_n` is high, clock edges shift nothing in. Any partly received byte is discarded, and the next byte starts again at its first bit.
- R3: `data_sel` is sampled only on the edge that completes a byte. High means display data and low means command. Its level during the earlier seven bits has no effect.
- R4: Command byte `1xxx_xxxx` loads X with its low seven bits when that value is between 0 and 101. A larger value leaves X unchanged.
- R5: Command byte `0100_yyyy` loads Y with `yyyy` when that value is between 0 and 8. A larger value leaves Y unchanged.
- R6: Command byte `0010_00m0`, with bit 0 ignored, sets the addressing mode to bit 1: 0 is horizontal and 1 is vertical. Every other command byte has no effect.
- R7: A data byte is stored at column X of bank Y on its completing edge. In bank 8 only bit 0 is kept, and bits 7 to 1 read back as 0.
- R8: In horizontal mode, a data write advances X by one. When X is 101 it goes to 0, and Y then advances by one, going from 8 to 0.
- R9: In vertical mode, a data write advances Y by one. When Y is 8 it goes to 0, and X then advances by one, going from 101 to 0.
- R10: A low `rst_n` at a rising `ser_clk` edge clears X, Y, the addressing mode and the bit counter.
- R11: `rd_byte` shows, without a clock, the stored byte at `rd_col` and `rd_bank`. It shows 0 when either index is out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_en_n | input | 1 | Active-low serial enable |
| ser_din | input | 1 | Serial data bit |
| data_sel | input | 1 | Byte type: 1 = display data, 0 = command |
| rd_col | input | 7 | Read-side column index |
| rd_bank | input | 4 | Read-side bank index |
| rd_byte | output | 8 | Stored byte at the read-side location |

## Verification
The assertions assume that `ser_clk` keeps running while reset is applied, so that the synchronous reset takes effect. They also assume that `data_sel` and `ser_din` are settled before each rising edge. The stimulus changes every input only on falling clock edges. It holds reset low for two full cycles, and it raises `ser_en_n` between bytes while the clock keeps running. Invalid X and Y values and unknown commands are sent on purpose. The range assertions therefore also show that these values never reach the address registers.

// File: rtl/dmw_pkg.sv
package dmw_pkg;
    // Kind of command carried by a command byte
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_SETX = 2'd1,
        CMD_SETY = 2'd2,
        CMD_MODE = 2'd3
    } cmd_e;

    // Classify a command byte by its high-order bits
    function automatic cmd_e cmd_decode(input logic [7:0] b);
        if (b[7])
            return CMD_SETX;
        else if (b[7:4] == 4'b0100)
            return CMD_SETY;
        else if (b[7:2] == 6'b001000)
            return CMD_MODE;
        else
            return CMD_NONE;
    endfunction
endpackage

// File: rtl/dmw_shift.sv
// Serial byte assembler.
// Shifts ser_din in MSB first on rising clock edges while enable is low.
// It raises byte_stb combinationally during the edge that will capture
// the last bit, and it presents the full byte together with the sampled select.
// Assumes a free-running clock; enable high clears the bit counter.
module dmw_shift #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_n,
    input  logic          din,
    input  logic          sel,
    output logic          byte_stb,
    output logic [BW-1:0] byte_val,
    output logic          byte_is_data
);
    localparam int CW = $clog2(BW);

    logic [CW-1:0] cnt;
    logic [BW-2:0] sh;

    // Bit counter and shift register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sh  <= '0;
        end else if (en_n) begin
            cnt <= '0;
        end else begin
            sh  <= {sh[BW-3:0], din};
            cnt <= (cnt == CW'(BW - 1)) ? '0 : cnt + 1'b1;
        end
    end

    // Completed byte is the held bits plus the bit on the line now
    always_comb begin
        byte_stb     = rst_n && !en_n && (cnt == CW'(BW - 1));
        byte_val     = {sh, din};
        byte_is_data = sel;
    end

    // R2
    enable_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> (cnt == '0));

    // R10
    reset_clears_cnt_chk: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0));
endmodule

// File: rtl/dmw_addr.sv
// Address and mode state.
// Decodes command bytes into X, Y and mode loads. It issues a write enable
// for data bytes and steps the address after each write in the chosen mode.
// Assumes byte_stb lasts exactly one clock for each received byte.
module dmw_addr
    import dmw_pkg::*;
#(
    parameter int NCOL = 102,
    parameter int NBANK = 9,
    parameter int XW = $clog2(NCOL),
    parameter int YW = $clog2(NBANK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_stb,
    input  logic [7:0]    byte_val,
    input  logic          byte_is_data,
    output logic          wr_en,
    output logic [XW-1:0] cur_x,
    output logic [YW-1:0] cur_y
);
    localparam logic [XW-1:0] XMAX = XW'(NCOL - 1);
    localparam logic [YW-1:0] YMAX = YW'(NBANK - 1);

    logic    vert;
    cmd_e    cmd;
    logic [XW-1:0] nx;
    logic [YW-1:0] ny;

    // Command kind and the address that follows a write
    always_comb begin
        cmd   = cmd_decode(byte_val);
        wr_en = byte_stb && byte_is_data;
        nx    = cur_x;
        ny    = cur_y;
        if (!vert) begin
            if (cur_x == XMAX) begin
                nx = '0;
                ny = (cur_y == YMAX) ? '0 : cur_y + 1'b1;
            end else begin
                nx = cur_x + 1'b1;
            end
        end else begin
            if (cur_y == YMAX) begin
                ny = '0;
                nx = (cur_x == XMAX) ? '0 : cur_x + 1'b1;
            end else begin
                ny = cur_y + 1'b1;
            end
        end
    end

    // Address and mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x <= '0;
            cur_y <= '0;
            vert  <= 1'b0;
        end else if (wr_en) begin
            cur_x <= nx;
            cur_y <= ny;
        end else if (byte_stb) begin
            case (cmd)
                CMD_SETX: if (byte_val[XW-1:0] <= XMAX) cur_x <= byte_val[XW-1:0];
                CMD_SETY: if (byte_val[YW-1:0] <= YMAX) cur_y <= byte_val[YW-1:0];
                CMD_MODE: vert <= byte_val[1];
                default:  ;
            endcase
        end
    end

    // R4
    x_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_x <= XMAX);

    // R5
    y_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_y <= YMAX);

    // R8
    horiz_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !vert && cur_x != XMAX) |=> (cur_x == $past(cur_x) + 1'b1) && $stable(cur_y));

    // R9
    vert_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && vert && cur_y != YMAX) |=> (cur_y == $past(cur_y) + 1'b1) && $stable(cur_x));

    // R10
    reset_addr_chk: assert property (@(posedge clk)
        !rst_n |=> (cur_x == '0) && (cur_y == '0) && !vert);
endmodule

// File: rtl/dmw_ram.sv
// Banked display memory.
// Column by bank storage with one write port and a combinational read port.
// The last bank keeps only its low TOP_BITS bits.
// Assumes write indices are always in range.
module dmw_ram #(
    parameter int NCOL = 102,
    parameter int NBANK = 9,
    parameter int BW = 8,
    parameter int TOP_BITS = 1,
    parameter int XW = $clog2(NCOL),
    parameter int YW = $clog2(NBANK)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [XW-1:0] wx,
    input  logic [YW-1:0] wy,
    input  logic [BW-1:0] wdata,
    input  logic [XW-1:0] rx,
    input  logic [YW-1:0] ry,
    output logic [BW-1:0] rdata
);
    localparam int DEPTH = NCOL * NBANK;
    localparam int AW = $clog2(DEPTH);
    localparam logic [BW-1:0] TOP_MASK = BW'((1 << TOP_BITS) - 1);

    logic [BW-1:0] mem [DEPTH];
    logic [AW-1:0] widx;
    logic [AW-1:0] ridx;
    logic [BW-1:0] wmasked;
    logic          rvalid;

    // Flat indices and the mask for the short bank
    always_comb begin
        widx    = AW'(int'(wy) * NCOL + int'(wx));
        ridx    = AW'(int'(ry) * NCOL + int'(rx));
        wmasked = (wy == YW'(NBANK - 1)) ? (wdata & TOP_MASK) : wdata;
        rvalid  = (rx < XW'(NCOL)) && (ry < YW'(NBANK));
        rdata   = rvalid ? mem[ridx] : '0;
    end

    // Memory write
    always_ff @(posedge clk) begin
        if (we)
            mem[widx] <= wmasked;
    end

    // R7
    always_comb begin
        if (we && wy == YW'(NBANK - 1))
            top_mask_chk: assert ((wmasked & ~TOP_MASK) == '0);
    end
endmodule

// File: rtl/serial_dotram_writer.sv
// Serial display RAM write controller top.
// Joins the byte assembler, the address and mode state, and the banked memory.
// Assumes all inputs are stable around rising ser_clk edges.
module serial_dotram_writer #(
    parameter int NCOL = 102,
    parameter int NBANK = 9,
    parameter int BW = 8,
    parameter int TOP_BITS = 1,
    parameter int XW = $clog2(NCOL),
    parameter int YW = $clog2(NBANK)
) (
    input  logic          ser_clk,
    input  logic          rst_n,
    input  logic          ser_en_n,
    input  logic          ser_din,
    input  logic          data_sel,
    input  logic [XW-1:0] rd_col,
    input  logic [YW-1:0] rd_bank,
    output logic [BW-1:0] rd_byte
);
    logic          stb;
    logic [BW-1:0] bval;
    logic          is_data;
    logic          wr_en;
    logic [XW-1:0] cx;
    logic [YW-1:0] cy;

    dmw_shift #(.BW(BW)) u_shift (
        .clk(ser_clk), .rst_n(rst_n), .en_n(ser_en_n), .din(ser_din),
        .sel(data_sel), .byte_stb(stb), .byte_val(bval), .byte_is_data(is_data)
    );

    dmw_addr #(.NCOL(NCOL), .NBANK(NBANK), .XW(XW), .YW(YW)) u_addr (
        .clk(ser_clk), .rst_n(rst_n), .byte_stb(stb), .byte_val(bval[7:0]),
        .byte_is_data(is_data), .wr_en(wr_en), .cur_x(cx), .cur_y(cy)
    );

    dmw_ram #(.NCOL(NCOL), .NBANK(NBANK), .BW(BW), .TOP_BITS(TOP_BITS),
              .XW(XW), .YW(YW)) u_ram (
        .clk(ser_clk), .we(wr_en), .wx(cx), .wy(cy), .wdata(bval),
        .rx(rd_col), .ry(rd_bank), .rdata(rd_byte)
    );
endmodule

// File: tb/serial_dotram_writer_tb.sv
module serial_dotram_writer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_n = 1'b1;
    logic       din = 1'b0;
    logic       sel = 1'b0;
    logic [6:0] rcol = '0;
    logic [3:0] rbank = '0;
    logic [7:0] rbyte;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    serial_dotram_writer u_dut (
        .ser_clk(clk), .rst_n(rst_n), .ser_en_n(en_n), .ser_din(din),
        .data_sel(sel), .rd_col(rcol), .rd_bank(rbank), .rd_byte(rbyte)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input int col, input int bank, input int exp);
        @(negedge clk);
        rcol = 7'(col);
        rbank = 4'(bank);
        #1;
        chk(req, int'(rbyte), exp);
    endtask

    // Send one byte; select may differ for the first seven bits and the last
    task automatic send(input logic [7:0] b, input logic sel_early, input logic sel_last);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            en_n = 1'b0;
            din = b[i];
            sel = (i == 0) ? sel_last : sel_early;
        end
        @(negedge clk);
        en_n = 1'b1;
    endtask

    task automatic cmd(input logic [7:0] b);
        send(b, 1'b0, 1'b0);
    endtask

    task automatic dat(input logic [7:0] b);
        send(b, 1'b1, 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        dat(8'hC1);
        dat(8'h3C);
        rd_chk("R10 R1 first write at 0,0", 0, 0, 'hC1);
        rd_chk("R8 next column", 1, 0, 'h3C);
    endtask

    task automatic t_horiz_wrap();
        cmd(8'h80 | 8'd100);
        cmd(8'h42);
        dat(8'h11); dat(8'h22); dat(8'h33);
        rd_chk("R4 R5 load x100 y2", 100, 2, 'h11);
        rd_chk("R8 x101", 101, 2, 'h22);
        rd_chk("R8 wrap to next bank", 0, 3, 'h33);
        cmd(8'h80 | 8'd101);
        cmd(8'h48);
        dat(8'hFF);
        dat(8'h77);
        rd_chk("R7 bank8 keeps bit0", 101, 8, 'h01);
        rd_chk("R8 corner wraps to 0,0", 0, 0, 'h77);
    endtask

    task automatic t_vertical();
        cmd(8'h22);
        cmd(8'h80 | 8'd5);
        cmd(8'h47);
        dat(8'h81); dat(8'h42); dat(8'h99);
        rd_chk("R9 write bank7", 5, 7, 'h81);
        rd_chk("R7 R9 bank8 bit0 zero", 5, 8, 'h00);
        rd_chk("R9 wrap to next column", 6, 0, 'h99);
        cmd(8'h80 | 8'd101);
        cmd(8'h48);
        dat(8'h01);
        dat(8'h5E);
        rd_chk("R9 corner", 101, 8, 'h01);
        rd_chk("R9 corner wraps to 0,0", 0, 0, 'h5E);
    endtask

    task automatic t_invalid_cmds();
        cmd(8'h21);
        cmd(8'h80 | 8'd10);
        cmd(8'h43);
        cmd(8'hE6);
        cmd(8'h49);
        cmd(8'h10);
        cmd(8'h00);
        dat(8'h5A);
        dat(8'h6B);
        rd_chk("R4 R5 out-of-range ignored", 10, 3, 'h5A);
        rd_chk("R6 mode bit0 ignored, horizontal", 11, 3, 'h6B);
        rd_chk("R11 column out of range", 102, 0, 0);
        rd_chk("R11 bank out of range", 0, 9, 0);
    endtask

    task automatic t_partial();
        cmd(8'h80 | 8'd20);
        cmd(8'h41);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            en_n = 1'b0;
            din = 1'b1;
            sel = 1'b1;
        end
        @(negedge clk);
        en_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            din = ~din;
        end
        dat(8'h6E);
        rd_chk("R2 partial byte discarded", 20, 1, 'h6E);
        rd_chk("R2 no extra write", 21, 1, 'h00);
    endtask

    task automatic t_sel_sample();
        cmd(8'h80 | 8'd30);
        cmd(8'h44);
        send(8'hA7, 1'b0, 1'b1);
        rd_chk("R3 late select high is data", 30, 4, 'hA7);
        send(8'h80 | 8'd40, 1'b1, 1'b0);
        dat(8'h19);
        rd_chk("R3 late select low is command", 40, 4, 'h19);
        rd_chk("R3 no stray data write", 31, 4, 'h00);
    endtask

    task automatic t_mid_reset();
        cmd(8'h22);
        cmd(8'h80 | 8'd50);
        do_reset();
        dat(8'hD2);
        dat(8'hE3);
        rd_chk("R10 address cleared", 0, 0, 'hD2);
        rd_chk("R10 mode cleared to horizontal", 1, 0, 'hE3);
    endtask

    initial begin
        // Clear row 31/21 targets to known zero before use
        repeat (2) @(negedge clk);
        t_reset_state();
        cmd(8'h80 | 8'd21); cmd(8'h41); dat(8'h00);
        cmd(8'h80 | 8'd31); cmd(8'h44); dat(8'h00);
        t_horiz_wrap();
        t_vertical();
        t_invalid_cmds();
        t_partial();
        t_sel_sample();
        t_mid_reset();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule